// File: doc/BRIEF.md
# Memory Semaphore Command Engine

This block executes semaphore commands for a command processor. Each command arrives as two 32-bit words with the packet header already removed. From these words the block takes a 40-bit, 8-byte-aligned address and an operation select. It then works on a 32-bit counter held at that address, using a memory port that carries one request at a time.

A signal command either adds one to the counter or overwrites it with 1. A wait command reads the counter repeatedly until the value is non-zero, and then writes back that value minus one. This consumes one unit of the semaphore. Between a zero read and the next read, the block leaves a configurable number of idle cycles. During the whole wait, the block raises a stall output so that the command processor can hold the queue that issued the command.

The block decodes and exposes two fields without acting on them: a client code and a mailbox flag. A select value it does not recognise ends the command at once with an error pulse and makes no memory access.

Top module: `mem_sem_engine`

## Requirements
- R1: The memory address is {dw2[7:0], dw1[31:3], 3'b000}. Bits 2:0 of dw1 are ignored, so the address is always 8-byte aligned.
- R2: The operation select is dw2[31:29], where 6 means signal and 7 means wait. Any other value gives an err_o pulse lasting one cycle, in the cycle after acceptance. That command issues no memory request, leaves the counter unchanged and gives no done_o.
- R3: For a signal, dw2[20] = 0 increments the counter. This is done with a read followed by a write of the read value plus 1, wrapping modulo 2^32. dw2[20] = 1 sets the counter to 1 with a single write and no read.
- R4: A wait reads the counter. When the value read is non-zero, the block writes back that value minus 1 and retires the command.
- R5: When a wait reads zero, the block drives no request for exactly RETRY_GAP cycles and then reads again.
- R6: stall_o is high from the cycle after a wait is accepted until the cycle after its decrementing write is acknowledged. It is low at all other times.
- R7: mem_lock_o is high for the whole read and the following write of every read-modify-write (increment, and a wait that reads a non-zero value). It is high only while a request is active, and it stays low for the set-to-1 write.
- R8: At most one memory request is outstanding. Address, write enable and write data stay stable from the cycle a request is raised until mem_ack_i.
- R9: cmd_ready_o is high only when the block is idle. A command is accepted on cmd_valid_i && cmd_ready_o, and a command presented while the block is busy has no effect.
- R10: done_o pulses combinationally in the cycle mem_ack_i acknowledges the final write of a signal or a wait.
- R11: cmd_client_o shows dw2[25:24] and cmd_mailbox_o shows dw2[16] of the last accepted command. Neither field changes the operation that is performed.
- R12: After reset, cmd_ready_o is 1 and mem_req_o, stall_o, done_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is being presented |
| cmd_ready_o | output | 1 | The engine is idle and can accept a command |
| cmd_dw1_i | input | 32 | First command word (low address bits) |
| cmd_dw2_i | input | 32 | Second command word (high address bits, select, type, client, mailbox) |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 40 | Byte address of the counter |
| mem_wdata_o | output | DATA_W | Write data |
| mem_lock_o | output | 1 | Read-modify-write in progress; other agents must not touch the address |
| mem_ack_i | input | 1 | Request completed; read data is valid |
| mem_rdata_i | input | DATA_W | Read data |
| stall_o | output | 1 | A wait command is in progress |
| done_o | output | 1 | The final write of the command has been acknowledged |
| err_o | output | 1 | The command had an unknown select and was dropped |
| cmd_client_o | output | 2 | Client code of the last accepted command |
| cmd_mailbox_o | output | 1 | Mailbox flag of the last accepted command |

## Verification
The latency figures assume a memory that acknowledges in the cycle after it sees a request. In this section, the first sample point is the negative edge that follows the accepting clock edge.
- An unknown select shows err_o at the first sample point.
- A set-to-1 shows done_o at the second sample point.
- An increment, or a wait on a non-zero counter, shows done_o at the fourth sample point.

The bench counts sample points from acceptance and compares the count with these figures. It does not simply wait for any response. On a zero read, it counts the request-free sample points that come before the next read and expects exactly RETRY_GAP. After completion, it reads the counter, the read and write counts and the locked-grant counts from its own memory model.

// File: rtl/mem_sem_pkg.sv
package mem_sem_pkg;
  localparam int ADDR_W   = 40;
  localparam int ALIGN_W  = 3;
  localparam logic [2:0] SEL_SIGNAL = 3'd6;
  localparam logic [2:0] SEL_WAIT   = 3'd7;

  typedef enum logic [1:0] {OP_INCR, OP_SET, OP_WAIT, OP_BAD} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_BACKOFF} state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    op_e               op;
    logic [1:0]        client;
    logic              mailbox;
  } cmd_t;
endpackage

// File: rtl/mem_sem_decode.sv
module mem_sem_decode
  import mem_sem_pkg::*;
(
  input  logic [31:0] dw1_i,
  input  logic [31:0] dw2_i,
  output cmd_t        cmd_o
);
  logic [2:0] sel;
  logic       set_one;
  logic       unused_fields;

  assign sel     = dw2_i[31:29];
  assign set_one = dw2_i[20];

  always_comb begin
    cmd_o.addr    = {dw2_i[7:0], dw1_i[31:ALIGN_W], {ALIGN_W{1'b0}}};
    cmd_o.client  = dw2_i[25:24];
    cmd_o.mailbox = dw2_i[16];
    if (sel == SEL_SIGNAL)    cmd_o.op = set_one ? OP_SET : OP_INCR;
    else if (sel == SEL_WAIT) cmd_o.op = OP_WAIT;
    else                      cmd_o.op = OP_BAD;
  end

  assign unused_fields = ^{dw1_i[2:0], dw2_i[28:26], dw2_i[23:21], dw2_i[19:17], dw2_i[15:8]};
endmodule

// File: rtl/mem_sem_update.sv
module mem_sem_update
  import mem_sem_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              zero_o
);
  assign zero_o = (rdata_i == '0);

  always_comb begin
    unique case (op_i)
      OP_INCR: wdata_o = rdata_i + DATA_W'(1);
      OP_WAIT: wdata_o = rdata_i - DATA_W'(1);
      OP_SET:  wdata_o = DATA_W'(1);
      default: wdata_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/mem_sem_backoff.sv
module mem_sem_backoff #(
  parameter int GAP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(GAP + 2);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(GAP);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  // last idle cycle of the gap
  assign expired_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/mem_sem_engine.sv
module mem_sem_engine
  import mem_sem_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RETRY_GAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [31:0]       cmd_dw1_i,
  input  logic [31:0]       cmd_dw2_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [39:0]       mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_lock_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              stall_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        cmd_client_o,
  output logic              cmd_mailbox_o
);
  state_e            state_q;
  cmd_t              dec, cmd_q;
  logic [DATA_W-1:0] wdata_q, upd_data;
  logic              rd_zero, err_q, gap_start, gap_done, accept;

  mem_sem_decode u_dec (
    .dw1_i (cmd_dw1_i),
    .dw2_i (cmd_dw2_i),
    .cmd_o (dec)
  );

  mem_sem_update #(.DATA_W(DATA_W)) u_upd (
    .op_i    (cmd_q.op),
    .rdata_i (mem_rdata_i),
    .wdata_o (upd_data),
    .zero_o  (rd_zero)
  );

  mem_sem_backoff #(.GAP(RETRY_GAP)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (gap_start),
    .expired_o (gap_done)
  );

  assign accept    = cmd_valid_i && (state_q == ST_IDLE);
  assign gap_start = (state_q == ST_READ) && mem_ack_i && (cmd_q.op == OP_WAIT) && rd_zero
                     && (RETRY_GAP != 0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '{addr: '0, op: OP_BAD, client: 2'b00, mailbox: 1'b0};
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cmd_q <= dec;
          unique case (dec.op)
            OP_BAD: err_q <= 1'b1;
            OP_SET: begin
              wdata_q <= DATA_W'(1);
              state_q <= ST_WRITE;
            end
            default: state_q <= ST_READ;
          endcase
        end
        ST_READ: if (mem_ack_i) begin
          if (cmd_q.op == OP_WAIT && rd_zero) begin
            // zero gap: re-request straight away
            state_q <= (RETRY_GAP == 0) ? ST_READ : ST_BACKOFF;
          end else begin
            wdata_q <= upd_data;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE:   if (mem_ack_i) state_q <= ST_IDLE;
        ST_BACKOFF: if (gap_done)  state_q <= ST_READ;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign mem_req_o     = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o      = (state_q == ST_WRITE);
  assign mem_addr_o    = cmd_q.addr;
  assign mem_wdata_o   = wdata_q;
  assign mem_lock_o    = (state_q == ST_READ) || ((state_q == ST_WRITE) && (cmd_q.op != OP_SET));
  assign stall_o       = (state_q != ST_IDLE) && (cmd_q.op == OP_WAIT);
  assign done_o        = (state_q == ST_WRITE) && mem_ack_i;
  assign err_o         = err_q;
  assign cmd_client_o  = cmd_q.client;
  assign cmd_mailbox_o = cmd_q.mailbox;
endmodule

// File: rtl/mem_sem_engine_chk.sv
module mem_sem_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [39:0]       mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_lock_o,
  input logic              mem_ack_i,
  input logic              stall_o,
  input logic              done_o,
  input logic              err_o
);
  a_r1_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);

  a_r8_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r8_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_ack_i |=> $stable(mem_wdata_o));

  a_r9_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mem_req_o && !stall_o);

  a_r9_accept_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> err_o || !cmd_ready_o);

  a_r10_done_on_write_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mem_req_o && mem_we_o && mem_ack_i);

  a_r2_err_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o && !done_o);

  a_r7_lock_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_lock_o |-> mem_req_o);

  a_r7_rmw_lock_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i && !stall_o |=> mem_req_o && mem_we_o && mem_lock_o);

  a_r6_stall_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && stall_o |=> !stall_o);
endmodule

bind mem_sem_engine mem_sem_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mem_sem_engine.sv
module tb_mem_sem_engine;
  localparam int DATA_W = 32;
  localparam int GAP    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [31:0]       dw1 = '0, dw2 = '0;
  logic              req, we, lock, ack = 1'b0;
  logic [39:0]       addr;
  logic [DATA_W-1:0] wdata, rdata = '0;
  logic              stall, done, err;
  logic [1:0]        client;
  logic              mailbox;

  int n_checks = 0, n_errors = 0;
  int n_rd = 0, n_wr = 0, n_lock = 0;
  logic [39:0] last_addr = '0;
  logic [DATA_W-1:0] mem [8];

  always #4 clk = ~clk;

  mem_sem_engine #(.DATA_W(DATA_W), .RETRY_GAP(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_dw1_i(dw1), .cmd_dw2_i(dw2), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_lock_o(lock), .mem_ack_i(ack),
    .mem_rdata_i(rdata), .stall_o(stall), .done_o(done), .err_o(err),
    .cmd_client_o(client), .cmd_mailbox_o(mailbox)
  );

  // memory model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (req && !ack) begin
      ack <= 1'b1;
      last_addr = addr;
      if (lock) n_lock = n_lock + 1;
      if (we) begin
        mem[addr[5:3]] = wdata;
        n_wr = n_wr + 1;
      end else begin
        rdata <= mem[addr[5:3]];
        n_rd = n_rd + 1;
      end
    end else begin
      ack <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // present a command and return the sample-point count until done/err
  task automatic run_cmd(input logic [31:0] a, input logic [31:0] b, output int lat);
    @(negedge clk);
    dw1 = a; dw2 = b; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!(done || err) && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  typedef struct packed {
    logic [31:0] d1;
    logic [31:0] d2;
    logic [31:0] init;
    logic [31:0] expv;
    logic        exp_err;
    logic [3:0]  exp_lat;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0008, 32'hC000_0012, 32'd5,          32'd6, 1'b0, 4'd4}, // R3 incr
    '{32'hABCD_0010, 32'hC010_007F, 32'd9,          32'd1, 1'b0, 4'd2}, // R3 set one
    '{32'h0000_0018, 32'hE000_0000, 32'd3,          32'd2, 1'b0, 4'd4}, // R4 wait
    '{32'h0000_0020, 32'hE201_0000, 32'd1,          32'd0, 1'b0, 4'd4}, // R11 client 2, mailbox
    '{32'h0000_0028, 32'hC100_00FF, 32'hFFFF_FFFF,  32'd0, 1'b0, 4'd4}, // R3 wrap
    '{32'h0000_0030, 32'h0000_0000, 32'd7,          32'd7, 1'b1, 4'd1}, // R2 sel 0
    '{32'h0000_0030, 32'hA000_0000, 32'd7,          32'd7, 1'b1, 4'd1}, // R2 sel 5
    '{32'h0000_003F, 32'hD010_0000, 32'd0,          32'd1, 1'b0, 4'd2}  // R1 low bits dropped
  };

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int lat, rd0, wr0, lk0, gap;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 ready", cmd_ready, 1);
    check("R12 req", req, 0);
    check("R12 stall", stall, 0);
    check("R12 done", done, 0);
    check("R12 err", err, 0);
    rst_n = 1'b1;

    foreach (VECS[v]) begin
      logic [2:0] sel, idx;
      logic is_sig, is_wait, is_set;
      sel = VECS[v].d2[31:29];
      is_sig  = (sel == 3'd6);
      is_wait = (sel == 3'd7);
      is_set  = is_sig && VECS[v].d2[20];
      idx = VECS[v].d1[5:3];
      mem[idx] = VECS[v].init;
      rd0 = n_rd; wr0 = n_wr; lk0 = n_lock;
      run_cmd(VECS[v].d1, VECS[v].d2, lat);
      check($sformatf("R2 err v%0d", v), err, VECS[v].exp_err);
      check($sformatf("R10 done v%0d", v), done, !VECS[v].exp_err);
      check($sformatf("R10 latency v%0d", v), lat, VECS[v].exp_lat);
      @(negedge clk);
      check($sformatf("R3 counter v%0d", v), mem[idx], VECS[v].expv);
      check($sformatf("R3 reads v%0d", v), n_rd - rd0, ((is_sig && !is_set) || is_wait) ? 1 : 0);
      check($sformatf("R8 writes v%0d", v), n_wr - wr0, (is_sig || is_wait) ? 1 : 0);
      check($sformatf("R7 locked grants v%0d", v), n_lock - lk0,
            ((is_sig && !is_set) || is_wait) ? 2 : 0);
      if (is_sig || is_wait)
        check($sformatf("R1 address v%0d", v), last_addr,
              {VECS[v].d2[7:0], VECS[v].d1[31:3], 3'b000});
      check($sformatf("R11 client v%0d", v), client, VECS[v].d2[25:24]);
      check($sformatf("R11 mailbox v%0d", v), mailbox, VECS[v].d2[16]);
      check($sformatf("R9 idle v%0d", v), cmd_ready, 1);
    end

    // wait on an empty semaphore: back-off, stall, busy handshake
    mem[0] = '0;
    mem[5] = 32'd42;
    @(negedge clk);
    dw1 = 32'h0; dw2 = 32'hE000_0000; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R6 stall after accept", stall, 1);
    check("R9 busy not ready", cmd_ready, 0);
    rd0 = n_rd;
    lat = 0;
    while (n_rd == rd0 && lat < 100) begin @(negedge clk); lat++; end
    gap = 0;
    lat = 0;
    while (lat < 100) begin
      @(negedge clk);
      lat++;
      if (!req) gap++;
      else if (gap > 0) break;
    end
    check("R5 retry gap", gap, GAP);
    check("R6 stall while polling", stall, 1);
    // R9: command offered while busy is ignored
    dw1 = 32'h0000_0028; dw2 = 32'hC010_0000; cmd_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 ready low while busy", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    repeat (2 * GAP) @(negedge clk);
    check("R4 still zero", mem[0], 0);
    mem[0] = 32'd2;
    lat = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    check("R10 wait completes", done, 1);
    check("R6 stall through final ack", stall, 1);
    @(negedge clk);
    check("R4 decremented", mem[0], 1);
    check("R6 stall released", stall, 0);
    check("R9 busy command ignored", mem[5], 42);

    // mid-run reset returns to the reset state
    mem[1] = '0;
    @(negedge clk);
    dw1 = 32'h8; dw2 = 32'hE000_0000; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset ready", cmd_ready, 1);
    check("R12 reset stall", stall, 0);
    check("R12 reset req", req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule